// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block stores the working registers of a small processor datapath. Every register has a 4-bit identifier. With the default parameters it holds fifteen 32-bit words. In each cycle it serves two independent reads and one write. Each read port takes an identifier and returns the addressed word combinationally, with no clock involved. The write port takes an identifier and a data word and updates storage on the rising clock edge.

The all-ones identifier, 0xF with the default width, is not a register. A write that names it changes nothing. A read that names it returns zero. This lets the surrounding control logic turn off any port by steering its identifier to that value, with no separate enable wire.

There is no forwarding path. A read of the register that is being written in the same cycle returns the stored word until the clock edge has passed. A synchronous, active-high reset clears every register.

Top module: `rf_2r1w`

## Requirements
- R1: While `rst` is high at a rising edge, every register is cleared to zero. After reset, reads of identifiers 0 through 14 return 0.
- R2: When `wr_id` is below 15 at a rising edge, that register takes `wr_data`. A read of that identifier after the edge returns the new word.
- R3: Reads are combinational. A change of `rd_a_id` or `rd_b_id` between clock edges changes `rd_a_data` or `rd_b_data` to the addressed word within the same cycle.
- R4: The two reads and the write work at the same time and independently. Each read port returns its own register's word in the same cycle that a write is in progress.
- R5: In the cycle that writes register k, a read of identifier k returns the value held before that write. The new value appears only after the rising edge.
- R6: A write with `wr_id` equal to 15 (all ones) changes no register.
- R7: A read with identifier 15 (all ones) returns 0 on that port, whatever the registers contain.
- R8: A register whose identifier differs from `wr_id` at an edge keeps its value through that edge.
- R9: Reset has priority. A write requested in a cycle where `rst` is high has no effect, and the target register reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all registers |
| rd_a_id | input | ADDR_W (4) | Identifier for read port A; all ones reads zero |
| rd_a_data | output | DATA_W (32) | Word addressed by `rd_a_id` |
| rd_b_id | input | ADDR_W (4) | Identifier for read port B; all ones reads zero |
| rd_b_data | output | DATA_W (32) | Word addressed by `rd_b_id` |
| wr_id | input | ADDR_W (4) | Destination identifier; all ones suppresses the write |
| wr_data | input | DATA_W (32) | Word stored at the next rising edge |

## Verification
The bench builds the block with its default parameters: a 4-bit identifier and 32-bit words. With a 4-bit identifier, every one of the fifteen registers and the reserved all-ones identifier can be reached, so each register can be read back in full after a write, after a suppressed write and after reset. The 32-bit width lets each register hold a distinct pattern derived from its index. Because of this, a wrong decode or a stale value on either read port shows up as a data mismatch, not as an accidental match.

// File: rtl/rf_pkg.sv
package rf_pkg;

    // Default word width and identifier width of the register file
    localparam int RF_DATA_W = 32;
    localparam int RF_ADDR_W = 4;

    // The all-ones identifier is reserved as "no register"
    function automatic int rf_null_id(input int addr_w);
        return (1 << addr_w) - 1;
    endfunction

    // Every identifier except the reserved one names a real register
    function automatic int rf_depth(input int addr_w);
        return (1 << addr_w) - 1;
    endfunction

endpackage

// File: rtl/rf_write_decode.sv
module rf_write_decode #(
    parameter int ADDR_W   = rf_pkg::RF_ADDR_W,
    parameter int NUM_REGS = rf_pkg::rf_depth(ADDR_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] wr_id,
    output logic [NUM_REGS-1:0] wr_sel
);

    // One select line per register. The reserved identifier lies outside
    // 0..NUM_REGS-1, so it raises no line.
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_sel
        assign wr_sel[gi] = (wr_id == ADDR_W'(gi));
    end

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_sel));

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int DATA_W   = rf_pkg::RF_DATA_W,
    parameter int NUM_REGS = rf_pkg::rf_depth(rf_pkg::RF_ADDR_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_REGS-1:0] wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   regs_q [NUM_REGS]
);

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rst) begin
                regs_q[i] <= '0;
            end else if (wr_sel[i]) begin
                regs_q[i] <= wr_data;
            end
        end
    end

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_chk
        // R8
        hold_unselected_chk: assert property (@(posedge clk) disable iff (rst)
            !wr_sel[gi] |=> $stable(regs_q[gi]));
        // R1
        reset_clear_chk: assert property (@(posedge clk)
            rst |=> (regs_q[gi] == '0));
    end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int DATA_W   = rf_pkg::RF_DATA_W,
    parameter int ADDR_W   = rf_pkg::RF_ADDR_W,
    parameter int NUM_REGS = rf_pkg::rf_depth(ADDR_W)
) (
    input  logic [ADDR_W-1:0] rd_id,
    input  logic [DATA_W-1:0] regs_q [NUM_REGS],
    output logic [DATA_W-1:0] rd_data
);

    // Pure mux: the reserved identifier and anything past the top
    // register read as zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_id == ADDR_W'(i)) begin
                rd_data = regs_q[i];
            end
        end
    end

endmodule

// File: rtl/rf_2r1w.sv
module rf_2r1w #(
    parameter int DATA_W = rf_pkg::RF_DATA_W,
    parameter int ADDR_W = rf_pkg::RF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_a_id,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [ADDR_W-1:0] rd_b_id,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic [ADDR_W-1:0] wr_id,
    input  logic [DATA_W-1:0] wr_data
);

    localparam int NUM_REGS = rf_pkg::rf_depth(ADDR_W);
    localparam logic [ADDR_W-1:0] NULL_ID = ADDR_W'(rf_pkg::rf_null_id(ADDR_W));

    typedef struct packed {
        logic [ADDR_W-1:0] id;
        logic [DATA_W-1:0] data;
    } wr_cmd_t;

    wr_cmd_t             wr_cmd;
    logic [NUM_REGS-1:0] wr_sel;
    logic [DATA_W-1:0]   regs_q [NUM_REGS];

    assign wr_cmd = '{id: wr_id, data: wr_data};

    rf_write_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .wr_id  (wr_cmd.id),
        .wr_sel (wr_sel)
    );

    rf_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_sel  (wr_sel),
        .wr_data (wr_cmd.data),
        .regs_q  (regs_q)
    );

    // Both read ports come from the same parameterized mux
    for (genvar gp = 0; gp < 2; gp++) begin : g_rd
        logic [ADDR_W-1:0] id_in;
        logic [DATA_W-1:0] data_out;
        assign id_in = (gp == 0) ? rd_a_id : rd_b_id;
        rf_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_rd (
            .rd_id   (id_in),
            .regs_q  (regs_q),
            .rd_data (data_out)
        );
    end

    assign rd_a_data = g_rd[0].data_out;
    assign rd_b_data = g_rd[1].data_out;

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_id != NULL_ID) |=> (regs_q[$past(wr_id)] == $past(wr_data)));

    // R7
    null_read_a_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_a_id == NULL_ID) |-> (rd_a_data == '0));

    // R7
    null_read_b_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_b_id == NULL_ID) |-> (rd_b_data == '0));

    // R6
    null_write_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_id == NULL_ID) |-> (wr_sel == '0));

endmodule

// File: tb/rf_2r1w_tb.sv
module rf_2r1w_tb;

    localparam int DW = 32;
    localparam int AW = 4;
    localparam int NR = 15;
    localparam logic [AW-1:0] NUL = 4'hF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] rd_a_id = '0;
    logic [AW-1:0] rd_b_id = '0;
    logic [AW-1:0] wr_id = NUL;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_a_data;
    logic [DW-1:0] rd_b_data;

    rf_2r1w #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst),
        .rd_a_id(rd_a_id), .rd_a_data(rd_a_data),
        .rd_b_id(rd_b_id), .rd_b_data(rd_b_data),
        .wr_id(wr_id), .wr_data(wr_data)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        bit          port_b;
        logic [DW-1:0] exp;
        string       tag;
    } item_t;

    item_t         sb_q[$];
    logic [DW-1:0] model [NR];
    int            checks = 0;
    int            failures = 0;
    bit            done = 0;
    event          sample_ev;

    function automatic logic [DW-1:0] model_rd(input logic [AW-1:0] id);
        if (id == NUL) return '0;
        return model[id];
    endfunction

    function automatic logic [DW-1:0] pattern(input int i, input int salt);
        return DW'(32'h9E37_0000 ^ (i * 32'h0101_1011) ^ (salt << 20));
    endfunction

    // Monitor: pops expected items and compares them against the ports
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [DW-1:0] act;
                it = sb_q.pop_front();
                act = it.port_b ? rd_b_data : rd_a_data;
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s port %s actual=%h expected=%h",
                             it.tag, it.port_b ? "B" : "A", act, it.exp);
                end
            end
        end
    end

    task automatic push_reads(input string tag);
        item_t ia;
        item_t ib;
        ia = '{port_b: 1'b0, exp: model_rd(rd_a_id), tag: tag};
        ib = '{port_b: 1'b1, exp: model_rd(rd_b_id), tag: tag};
        sb_q.push_back(ia);
        sb_q.push_back(ib);
        -> sample_ev;
        #1;
    endtask

    // One clock cycle: drive at negedge, check reads before the edge,
    // then update the model at the rising edge.
    task automatic cycle_op(input logic r, input logic [AW-1:0] wid,
                            input logic [DW-1:0] wd, input logic [AW-1:0] ra,
                            input logic [AW-1:0] rb, input string tag);
        @(negedge clk);
        rst = r; wr_id = wid; wr_data = wd; rd_a_id = ra; rd_b_id = rb;
        #1;
        push_reads(tag);
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < NR; i++) model[i] = '0;
        end else if (wid != NUL) begin
            model[wid] = wd;
        end
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < NR; i += 2) begin
            cycle_op(1'b0, NUL, '0, AW'(i), AW'((i + 1) % NR), tag);
        end
    endtask

    initial begin
        for (int i = 0; i < NR; i++) model[i] = 'x;
        cycle_op(1'b1, NUL, '0, NUL, NUL, "R1");
        cycle_op(1'b1, NUL, '0, NUL, NUL, "R1");
        // R1: all registers zero after reset
        read_all("R1");

        // R4 / R5: write k while reading k (old value) and k+1
        for (int i = 0; i < NR; i++) begin
            cycle_op(1'b0, AW'(i), pattern(i, 1), AW'(i), AW'((i + 1) % NR), "R4_R5");
        end
        // R2: every written word visible after its edge
        read_all("R2");

        // R2 / R8: overwrite one register, others must hold
        cycle_op(1'b0, 4'd7, 32'hDEAD_BEEF, 4'd7, 4'd6, "R5");
        cycle_op(1'b0, NUL, '0, 4'd7, 4'd8, "R2");
        read_all("R8");

        // R6: write to the reserved identifier changes nothing
        cycle_op(1'b0, NUL, 32'hFFFF_FFFF, 4'd0, 4'd14, "R6");
        cycle_op(1'b0, NUL, 32'h1234_5678, 4'd3, 4'd9, "R6");
        read_all("R6");

        // R7: reserved identifier reads zero on both ports
        cycle_op(1'b0, NUL, '0, NUL, NUL, "R7");
        cycle_op(1'b0, 4'd2, 32'hA5A5_0001, NUL, 4'd2, "R7");

        // R3: address changes between edges, no clock needed
        @(negedge clk);
        wr_id = NUL;
        for (int i = 0; i < NR; i++) begin
            rd_a_id = AW'(i);
            rd_b_id = AW'(NR - 1 - i);
            #0.2;
            push_reads("R3");
            if (i % 3 == 2) @(negedge clk);
        end

        // R9: reset wins over a same-cycle write; R1 clears mid-run
        cycle_op(1'b1, 4'd3, 32'hCAFE_F00D, 4'd3, 4'd4, "R9");
        cycle_op(1'b0, NUL, '0, 4'd3, 4'd4, "R9");
        read_all("R1");

        // Short burst with a distinct pattern after reset
        for (int i = 0; i < NR; i++) begin
            cycle_op(1'b0, AW'(NR - 1 - i), pattern(i, 5), AW'(NR - 1 - i), NUL, "R5");
        end
        read_all("R2");

        #2;
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule